// File: doc/BRIEF.md
# Host DMA Mailbox Request Controller

This block is an 8-bit control register that a local CPU uses to run two host DMA request channels, one per mailbox. Each write to the register either updates one or both request flags, or updates the configuration nibble. The configuration nibble holds a DMA enable bit and a pin-function select bit for each channel. Which of the two happens is chosen by two gate bits that the write carries. These gate bits are never stored.

Each channel drives a request output and an output enable. When the output enable is low, the pad is tri-stated. The select bits are also brought out so that pad multiplexing can choose the alternate function. A request flag clears itself once the host finishes a byte transfer, which it signals with an active-low acknowledge pulse. Two sticky "revision data available" flags read back as 1 after reset. Each one drops for good on the first CPU read of its mailbox transmit register.

Top module: `hdma_req_ctl`

## Requirements
- R1: After reset, `rdata` reads 8'hC0, and `req`, `req_oe` and `alt_sel` are all 0.
- R2: A write with wdata[7]=1 loads wdata[5] into the channel-1 request flag, which reads back on rdata[5]. The configuration bits rdata[3:0] are left unchanged.
- R3: A write with wdata[6]=1 loads wdata[4] into the channel-0 request flag, which reads back on rdata[4]. The configuration bits are left unchanged.
- R4: A write with wdata[7]=0 and wdata[6]=0 loads wdata[3:0] into the configuration and leaves both request flags unchanged. The configuration bits are: bit0 enables channel 0, bit1 enables channel 1, bit2 is the channel-0 select and bit3 is the channel-1 select.
- R5: The gate bits are not stored. A write without wdata[7] never changes flag 1, and a write without wdata[6] never changes flag 0. Each gate bit affects only its own channel.
- R6: For channel i, req_oe[i] is 1 exactly when its enable bit is 1 and its select bit is 0. req[i] is the request flag ANDed with req_oe[i].
- R7: alt_sel[1:0] equals the configuration bits {bit3, bit2}. A select value of 0 means the DMA function.
- R8: A transfer completes when ack_n[i] is sampled low while req[i] is high and is sampled high on the next clock. The flag is then 0 from the following cycle on. A low acknowledge has no effect while the request is not driven.
- R9: rdata[6] (channel 0) and rdata[7] (channel 1) are 1 after reset. Each clears one cycle after a tx0_rd or tx1_rd pulse respectively, and stays 0 until reset.
- R10: When a gated request write lands in the same cycle as a transfer completion on that channel, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data {avail1, avail0, flag1, flag0, cfg[3:0]} |
| tx0_rd | input | 1 | CPU read of the channel-0 transmit register |
| tx1_rd | input | 1 | CPU read of the channel-1 transmit register |
| ack_n | input | 2 | Host acknowledge per channel, active low |
| req | output | 2 | Host DMA request per channel |
| req_oe | output | 2 | Output enable for req, 0 means tri-stated |
| alt_sel | output | 2 | Pin-function select, 1 means the alternate function |

## Verification
A software write to a request flag can land in the same cycle as a hardware completion clear. The bench provokes this by holding a channel's acknowledge low for one cycle. It then raises the acknowledge at the very clock edge that carries a gated write setting the flag. The flag must read 1 afterwards. Without the collision, a plain acknowledge pulse must clear the flag, and that contrast is what judges the priority.

// File: rtl/hdma_req_ctl.sv
module hdma_req_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tx0_rd,
  input  logic       tx1_rd,
  input  logic [1:0] ack_n,
  output logic [1:0] req,
  output logic [1:0] req_oe,
  output logic [1:0] alt_sel
);
  logic [3:0] cfg;
  logic [1:0] flag, avail, ack_seen;

  wire [1:0] gate   = {wdata[7], wdata[6]} & {2{wr_en}};
  wire       cfg_we = wr_en & ~wdata[7] & ~wdata[6];
  wire [1:0] done   = ack_seen & ack_n;

  assign req_oe  = cfg[1:0] & ~cfg[3:2];
  assign req     = flag & req_oe;
  assign alt_sel = cfg[3:2];
  assign rdata   = {avail, flag, cfg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= 4'h0;
      flag     <= 2'b00;
      avail    <= 2'b11;
      ack_seen <= 2'b00;
    end else begin
      if (cfg_we) cfg <= wdata[3:0];
      for (int i = 0; i < 2; i++) begin
        if (gate[i])      flag[i] <= wdata[4+i];
        else if (done[i]) flag[i] <= 1'b0;
      end
      ack_seen <= req & ~ack_n;
      avail    <= avail & ~{tx1_rd, tx0_rd};
    end
  end
endmodule

module hdma_req_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       tx0_rd,
  input logic       tx1_rd,
  input logic [1:0] ack_n,
  input logic [1:0] req,
  input logic [1:0] req_oe
);
  a_r6_req_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~req_oe) == 2'b00);
  a_r2_flag1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[7]) |=> rdata[5] == $past(wdata[5]));
  a_r3_flag0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[6]) |=> rdata[4] == $past(wdata[4]));
  a_r4_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[7] && !wdata[6]) |=> rdata[3:0] == $past(wdata[3:0]));
  a_r5_flag1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[7] && !rdata[5]) |=> !rdata[5]);
  a_r8_ch0_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $rose(ack_n[0]) && $past(req[0])) |=> !rdata[4]);
  a_r8_ch1_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $rose(ack_n[1]) && $past(req[1])) |=> !rdata[5]);
  a_r9_tx0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx0_rd |=> !rdata[6]);
  a_r9_avail0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[6] |=> !rdata[6]);
  a_r9_avail1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[7] |=> !rdata[7]);
endmodule

bind hdma_req_ctl hdma_req_ctl_chk u_chk (.*);

// File: tb/test_hdma_req_ctl.sv
module test_hdma_req_ctl;
  logic clk = 0, rst_n = 0, wr_en = 0, tx0_rd = 0, tx1_rd = 0;
  logic [7:0] wdata = 0;
  logic [1:0] ack_n = 2'b11;
  logic [7:0] rdata;
  logic [1:0] req, req_oe, alt_sel;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hdma_req_ctl i_hdma_req_ctl (.*);

  // {wdata, rdata[5:0], req, req_oe, alt_sel}
  localparam logic [19:0] VEC [0:8] = '{
    {8'h03, 6'h03, 2'b00, 2'b11, 2'b00},
    {8'hD0, 6'h13, 2'b01, 2'b11, 2'b00},
    {8'hA0, 6'h33, 2'b11, 2'b11, 2'b00},
    {8'h0C, 6'h3C, 2'b00, 2'b00, 2'b11},
    {8'h02, 6'h32, 2'b10, 2'b10, 2'b00},
    {8'h6F, 6'h22, 2'b10, 2'b10, 2'b00},
    {8'h80, 6'h02, 2'b00, 2'b10, 2'b00},
    {8'h01, 6'h01, 2'b00, 2'b01, 2'b00},
    {8'h50, 6'h11, 2'b01, 2'b01, 2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ack_pulse(input int ch);
    @(negedge clk); ack_n[ch] = 0;
    @(negedge clk); ack_n[ch] = 1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata", rdata, 8'hC0);
    chk("R1 req/oe/alt", {req, req_oe, alt_sel}, 6'b0);

    for (int k = 0; k < 9; k++) begin
      wr(VEC[k][19:12]);
      chk($sformatf("R2 R3 R4 R5 vector %0d rdata", k), rdata[5:0], VEC[k][11:6]);
      chk($sformatf("R6 vector %0d req", k), req, VEC[k][5:4]);
      chk($sformatf("R6 vector %0d req_oe", k), req_oe, VEC[k][3:2]);
      chk($sformatf("R7 vector %0d alt_sel", k), alt_sel, VEC[k][1:0]);
    end
    chk("R9 avail untouched", rdata[7:6], 2'b11);

    wr(8'h03);
    wr(8'hA0);
    chk("R6 both requesting", req, 2'b11);
    ack_pulse(0);
    chk("R8 ch0 cleared, ch1 kept", rdata[5:4], 2'b10);

    @(negedge clk); ack_n[1] = 0;
    repeat (3) @(negedge clk);
    chk("R8 held low keeps flag", rdata[5], 1'b1);
    ack_n[1] = 1;
    @(negedge clk);
    chk("R8 ch1 cleared on release", rdata[5], 1'b0);

    wr(8'h00);
    wr(8'hD0);
    chk("R6 disabled no drive", {req, req_oe}, 4'b0);
    ack_pulse(0);
    chk("R8 ack ignored when not driven", rdata[4], 1'b1);

    wr(8'h03);
    @(negedge clk); ack_n[0] = 0;
    @(negedge clk); ack_n[0] = 1; wr_en = 1; wdata = 8'hD0;
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    chk("R10 write wins over completion", rdata[4], 1'b1);

    @(negedge clk); tx0_rd = 1;
    @(negedge clk); tx0_rd = 0;
    chk("R9 avail0 cleared", rdata[7:6], 2'b10);
    @(negedge clk); tx1_rd = 1;
    @(negedge clk); tx1_rd = 0;
    repeat (2) @(negedge clk);
    chk("R9 both cleared and sticky", rdata[7:6], 2'b00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule